// File: doc/BRIEF.md
# SDRAM bank window decoder

This block keeps the configuration of a small set of memory banks and uses it to steer physical addresses. Each bank is described by one packed register carrying an 8 MiB-aligned base, a 10-bit size code and an enable flag. Software programs these registers over a simple device control register bus. It can reach each bank register at its own register number, or go through an indirect pair: one register holds an index and a second one forwards reads and writes to the bank that the index selects.

On the lookup side the block takes a physical address and, in the same cycle, reports whether an enabled bank covers it. On a hit it also gives the winning bank's index and the byte offset of the address inside that bank's window. A downstream memory controller uses this result to pick a chip select and to form the in-bank address.

Top module: `bkwin_decoder`

## Requirements
- R1: After reset every bank register reads 0, the indirect index reads 0 and no address hits.
- R2: Bank i has its own register at register number 0x40+i and can be written and read back there.
- R3: A write stores the data ANDed with 0xFFDEE001; every other bit reads back 0.
- R4: Bit 0 of a bank register enables the bank; a bank with bit 0 clear never hits.
- R5: A bank window starts at the register value ANDed with 0xFF800000 and spans (1024 − code) × 8 MiB, where code is bits 15:6 of the register. An address hits when base ≤ address < base + span, and a window running past the top of the address space covers every address up to the top.
- R6: A bank whose size code is 0 never hits.
- R7: When more than one enabled bank covers an address, the lowest-numbered bank is reported.
- R8: The lookup outputs are combinational: a hit gives the bank index and offset = address − base, and a miss gives hit 0, bank 0 and offset 0.
- R9: A write to register 0x10 stores its low 8 bits as the indirect index, and a read of 0x10 returns that index. Reads and writes at register 0x11 act on the bank register that the index selects, where index 0 is bank 0.
- R10: Through register 0x11, an index at or beyond the bank count reads 0 and ignores writes. Register numbers with no register behind them also read 0 and ignore writes. The read data is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Register access in this cycle |
| cfg_write | input | 1 | 1 for a write, 0 for a read |
| cfg_num | input | 10 | Register number |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| lk_addr | input | 32 | Physical address to decode |
| lk_hit | output | 1 | An enabled bank covers lk_addr |
| lk_bank | output | 2 | Index of the winning bank |
| lk_offset | output | 32 | lk_addr minus the winning bank's base |

## Verification
The bench probes both ends of each window: the first byte, the last byte and the byte just past the end. A design that compares with the wrong bound therefore loses or gains exactly one byte. It places a window so that it runs past the top of the address space, where a sum held without a carry bit wraps round and the top addresses miss. It sets up overlapping banks, which shows whether priority is inverted. It also sets up size code 0 and disabled banks, which a decoder that ignores these fields would wrongly report as hits. Through the indirect pair it uses out-of-range indices, and it writes all-ones data to catch a store that keeps unimplemented bits.

// File: rtl/bkwin_pkg.sv
package bkwin_pkg;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_BANK,
      ACC_PTR,
      ACC_DATA
   } acc_e;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bkwin_regs.sv
module bkwin_regs
   import bkwin_pkg::*;
#(
   parameter int unsigned NUM_BANKS     = 4,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned NUM_W         = 10,
   parameter int unsigned IDX_W         = 8,
   parameter int unsigned BANK_BASE_NUM = 'h40,
   parameter int unsigned IND_ADDR_NUM  = 'h10,
   parameter int unsigned IND_DATA_NUM  = 'h11,
   parameter logic [DATA_W-1:0] IMPL_MASK = 32'hFFDE_E001
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_valid,
   input  logic                              cfg_write,
   input  logic [NUM_W-1:0]                  cfg_num,
   input  logic [DATA_W-1:0]                 cfg_wdata,
   output logic [DATA_W-1:0]                 cfg_rdata,
   output logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_regs
);

   localparam int unsigned BSEL_W = sel_width(NUM_BANKS);

   if (NUM_BANKS < 1 || NUM_BANKS > 64) begin : g_bad_banks
      $error("bkwin_regs: NUM_BANKS out of range");
   end
   if (IDX_W < BSEL_W || IDX_W > DATA_W) begin : g_bad_idx
      $error("bkwin_regs: IDX_W cannot address every bank");
   end
   if (NUM_W > 31) begin : g_bad_num
      $error("bkwin_regs: NUM_W too wide");
   end

   acc_e                              acc;
   logic [BSEL_W-1:0]                 tgt;
   logic                              tgt_ok;
   logic [IDX_W-1:0]                  idx_q;
   logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_q;
   logic [31:0]                       num_u;
   logic                              wr_en;

   assign num_u = 32'(cfg_num);
   assign wr_en = cfg_valid && cfg_write;

   // Decode the register number into an access kind and a bank target
   always_comb begin
      acc    = ACC_NONE;
      tgt    = '0;
      tgt_ok = 1'b0;
      if (num_u >= BANK_BASE_NUM && num_u < BANK_BASE_NUM + NUM_BANKS) begin
         acc    = ACC_BANK;
         tgt    = BSEL_W'(num_u - BANK_BASE_NUM);
         tgt_ok = 1'b1;
      end else if (num_u == IND_ADDR_NUM) begin
         acc = ACC_PTR;
      end else if (num_u == IND_DATA_NUM) begin
         acc = ACC_DATA;
         if (32'(idx_q) < NUM_BANKS) begin
            tgt    = idx_q[BSEL_W-1:0];
            tgt_ok = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         idx_q  <= '0;
      end else if (wr_en) begin
         if (acc == ACC_PTR) begin
            idx_q <= cfg_wdata[IDX_W-1:0];
         end
         for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (tgt_ok && tgt == BSEL_W'(b)) begin
               bank_q[b] <= cfg_wdata & IMPL_MASK;
            end
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_valid && !cfg_write) begin
         if (acc == ACC_PTR) begin
            cfg_rdata = DATA_W'(idx_q);
         end else if (tgt_ok) begin
            cfg_rdata = bank_q[tgt];
         end
      end
   end

   assign bank_regs = bank_q;

   // Assertions guarding the store path
   p_ptr_write_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && num_u == IND_ADDR_NUM) |=> idx_q == $past(cfg_wdata[IDX_W-1:0]));

   p_idle_read_zero_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_valid && !cfg_write) |-> cfg_rdata == '0);

   p_bad_index_ignored_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && num_u == IND_DATA_NUM && 32'(idx_q) >= NUM_BANKS) |=> $stable(bank_q));

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
      p_masked_store_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         (bank_q[g] & ~IMPL_MASK) == '0);

      p_direct_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && num_u == BANK_BASE_NUM + g)
         |=> bank_q[g] == ($past(cfg_wdata) & IMPL_MASK));
   end

endmodule

// File: rtl/bkwin_match.sv
module bkwin_match #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned BASE_LSB = 23,
   parameter int unsigned SIZE_LSB = 6,
   parameter int unsigned SIZE_W   = 10
) (
   input  logic [DATA_W-1:0] cfg,
   input  logic [ADDR_W-1:0] addr,
   output logic              match,
   output logic [ADDR_W-1:0] offset
);

   localparam int unsigned SPAN_W = SIZE_W + 1 + BASE_LSB;
   localparam int unsigned EXT_W  = ((ADDR_W > SPAN_W) ? ADDR_W : SPAN_W) + 1;
   localparam logic [ADDR_W-1:0] BASE_MASK =
      ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("bkwin_match: address wider than register");
   end
   if (BASE_LSB >= ADDR_W || BASE_LSB == 0) begin : g_bad_base
      $error("bkwin_match: BASE_LSB out of range");
   end
   if (SIZE_LSB == 0 || SIZE_LSB + SIZE_W > DATA_W) begin : g_bad_size
      $error("bkwin_match: size field overlaps enable or leaves the register");
   end

   logic [ADDR_W-1:0] base;
   logic [SIZE_W-1:0] code;
   logic [SIZE_W:0]   units;
   logic [EXT_W-1:0]  limit;
   logic              en;
   logic              unused_cfg;

   assign en    = cfg[0];
   assign base  = cfg[ADDR_W-1:0] & BASE_MASK;
   assign code  = cfg[SIZE_LSB +: SIZE_W];
   assign units = (SIZE_W+1)'(1 << SIZE_W) - {1'b0, code};
   // The limit carries an extra bit so windows running past the top never wrap
   assign limit = EXT_W'(base) + (EXT_W'(units) << BASE_LSB);

   assign match  = en && (code != '0) && (addr >= base) && (EXT_W'(addr) < limit);
   assign offset = addr - base;

   assign unused_cfg = ^cfg;

endmodule

// File: rtl/bkwin_pick.sv
module bkwin_pick
   import bkwin_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 32
) (
   input  logic [NUM_BANKS-1:0]              match_vec,
   input  logic [NUM_BANKS-1:0][ADDR_W-1:0]  offs,
   output logic                              hit,
   output logic [sel_width(NUM_BANKS)-1:0]   bank,
   output logic [ADDR_W-1:0]                 offset
);

   localparam int unsigned BSEL_W = sel_width(NUM_BANKS);

   if (NUM_BANKS == 1) begin : g_single
      assign hit    = match_vec[0];
      assign bank   = '0;
      assign offset = match_vec[0] ? offs[0] : '0;
   end else begin : g_multi
      // Scan from the top down so the lowest matching bank is written last
      always_comb begin
         hit    = 1'b0;
         bank   = '0;
         offset = '0;
         for (int i = int'(NUM_BANKS) - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
               hit    = 1'b1;
               bank   = BSEL_W'(i);
               offset = offs[i];
            end
         end
      end
   end

endmodule

// File: rtl/bkwin_decoder.sv
module bkwin_decoder
   import bkwin_pkg::*;
#(
   parameter int unsigned NUM_BANKS     = 4,
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned NUM_W         = 10,
   parameter int unsigned IDX_W         = 8,
   parameter int unsigned BANK_BASE_NUM = 'h40,
   parameter int unsigned IND_ADDR_NUM  = 'h10,
   parameter int unsigned IND_DATA_NUM  = 'h11,
   parameter logic [DATA_W-1:0] IMPL_MASK = 32'hFFDE_E001,
   parameter int unsigned BASE_LSB      = 23,
   parameter int unsigned SIZE_LSB      = 6,
   parameter int unsigned SIZE_W        = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_valid,
   input  logic                            cfg_write,
   input  logic [NUM_W-1:0]                cfg_num,
   input  logic [DATA_W-1:0]               cfg_wdata,
   output logic [DATA_W-1:0]               cfg_rdata,
   input  logic [ADDR_W-1:0]               lk_addr,
   output logic                            lk_hit,
   output logic [sel_width(NUM_BANKS)-1:0] lk_bank,
   output logic [ADDR_W-1:0]               lk_offset
);

   logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_regs;
   logic [NUM_BANKS-1:0]              match_vec;
   logic [NUM_BANKS-1:0][ADDR_W-1:0]  offs;

   bkwin_regs #(
      .NUM_BANKS     (NUM_BANKS),
      .DATA_W        (DATA_W),
      .NUM_W         (NUM_W),
      .IDX_W         (IDX_W),
      .BANK_BASE_NUM (BANK_BASE_NUM),
      .IND_ADDR_NUM  (IND_ADDR_NUM),
      .IND_DATA_NUM  (IND_DATA_NUM),
      .IMPL_MASK     (IMPL_MASK)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_write (cfg_write),
      .cfg_num   (cfg_num),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .bank_regs (bank_regs)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_win
      bkwin_match #(
         .ADDR_W   (ADDR_W),
         .DATA_W   (DATA_W),
         .BASE_LSB (BASE_LSB),
         .SIZE_LSB (SIZE_LSB),
         .SIZE_W   (SIZE_W)
      ) u_match (
         .cfg    (bank_regs[g]),
         .addr   (lk_addr),
         .match  (match_vec[g]),
         .offset (offs[g])
      );
   end

   bkwin_pick #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) u_pick (
      .match_vec (match_vec),
      .offs      (offs),
      .hit       (lk_hit),
      .bank      (lk_bank),
      .offset    (lk_offset)
   );

   // Lookup-side assertions
   p_hit_enabled_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> bank_regs[lk_bank][0]);

   p_hit_code_valid_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> bank_regs[lk_bank][SIZE_LSB +: SIZE_W] != '0);

   p_lowest_wins_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (match_vec[lk_bank] &&
                  (match_vec & ((NUM_BANKS'(1) << lk_bank) - NUM_BANKS'(1))) == '0));

   p_miss_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_bank == '0 && lk_offset == '0 && match_vec == '0));

   p_offset_below_addr_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_offset <= lk_addr);

endmodule

// File: tb/bkwin_decoder_tb.sv
module bkwin_decoder_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] MASK = 32'hFFDE_E001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic        cfg_write = 1'b0;
   logic [9:0]  cfg_num = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] lk_addr = '0;
   logic        lk_hit;
   logic [1:0]  lk_bank;
   logic [31:0] lk_offset;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_bank [4];
   logic [7:0]  m_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   bkwin_decoder u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_write (cfg_write),
      .cfg_num   (cfg_num),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .lk_addr   (lk_addr),
      .lk_hit    (lk_hit),
      .lk_bank   (lk_bank),
      .lk_offset (lk_offset)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [9:0] num);
      if (num >= 10'h40 && num <= 10'h43) return m_bank[num - 10'h40];
      if (num == 10'h10) return {24'b0, m_idx};
      if (num == 10'h11 && m_idx < 8'd4) return m_bank[m_idx[1:0]];
      return 32'h0;
   endfunction

   task automatic model_write(input logic [9:0] num, input logic [31:0] d);
      if (num >= 10'h40 && num <= 10'h43) m_bank[num - 10'h40] = d & MASK;
      else if (num == 10'h10) m_idx = d[7:0];
      else if (num == 10'h11 && m_idx < 8'd4) m_bank[m_idx[1:0]] = d & MASK;
   endtask

   task automatic exp_decode(input logic [31:0] a, output logic h,
                             output logic [1:0] b, output logic [31:0] o);
      logic [63:0] base64, size64, a64;
      logic [9:0]  code;
      h = 1'b0; b = '0; o = '0;
      a64 = {32'b0, a};
      for (int i = 3; i >= 0; i--) begin
         code   = m_bank[i][15:6];
         base64 = {32'b0, m_bank[i][31:23], 23'b0};
         size64 = 64'(1024 - int'(code)) << 23;
         if (m_bank[i][0] && code != 0 && a64 >= base64 && a64 < base64 + size64) begin
            h = 1'b1;
            b = 2'(i);
            o = a - base64[31:0];
         end
      end
   endtask

   task automatic wr(input logic [9:0] num, input logic [31:0] d);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b1; cfg_num = num; cfg_wdata = d;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0;
      model_write(num, d);
   endtask

   task automatic rd(input logic [9:0] num, input string req);
      logic [31:0] e;
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b0; cfg_num = num;
      #1;
      e = model_read(num);
      check(cfg_rdata === e, req, cfg_rdata, e);
      cfg_valid = 1'b0;
   endtask

   task automatic lk(input logic [31:0] a, input string req);
      logic h; logic [1:0] b; logic [31:0] o;
      @(negedge clk);
      lk_addr = a;
      #1;
      exp_decode(a, h, b, o);
      check(lk_hit === h, {req, " hit"}, 32'(lk_hit), 32'(h));
      check(lk_bank === b, {req, " bank"}, 32'(lk_bank), 32'(b));
      check(lk_offset === o, {req, " offset"}, lk_offset, o);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] base, v;
      logic [63:0] end64;
      void'($urandom(32'd4242));
      for (int i = 0; i < 4; i++) m_bank[i] = '0;
      m_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 4; i++) rd(10'(10'h40 + i), "R1");
      rd(10'h10, "R1");
      rd(10'h11, "R1");
      lk(32'h0, "R1");
      lk(32'hFFFF_FFFF, "R1");

      // R3: all-ones write keeps only implemented bits; R2 read back
      wr(10'h40, 32'hFFFF_FFFF);
      rd(10'h40, "R3");
      check(model_read(10'h40) == 32'hFFDE_E001, "R3 model", model_read(10'h40), 32'hFFDE_E001);
      // R5: window past the top of the address space covers up to the top
      lk(32'hFFFF_FFFF, "R5 top");
      lk(32'hFF80_0000, "R5 top base");
      lk(32'hFF7F_FFFF, "R5 below base");
      wr(10'h40, 32'h0);

      // R5/R2: 1 GiB window at 0x1000_0000 in bank 1
      wr(10'h41, 32'h1000_E001);
      rd(10'h41, "R2");
      lk(32'h0FFF_FFFF, "R5 before");
      lk(32'h1000_0000, "R5 first");
      lk(32'h4FFF_FFFF, "R5 last");
      lk(32'h5000_0000, "R5 past");
      lk(32'h2345_6789, "R8 offset");

      // R6: size code 0; R4: disabled bank
      wr(10'h42, 32'h6000_0001);
      lk(32'h6000_0000, "R6");
      wr(10'h42, 32'h6000_E000);
      lk(32'h6000_0000, "R4");
      lk(32'h6100_0000, "R4");

      // R7: overlap priority
      wr(10'h42, 32'h1000_E001);
      lk(32'h1800_0000, "R7 b1 over b2");
      wr(10'h40, 32'h1800_2001);
      lk(32'h1800_0000, "R7 b0 over b1");
      lk(32'h17FF_FFFF, "R7 below b0");

      // R9: indirect path
      wr(10'h10, 32'hABCD_0103);
      rd(10'h10, "R9");
      wr(10'h10, 32'h3);
      wr(10'h11, 32'h7000_6001);
      rd(10'h43, "R9");
      rd(10'h11, "R9");
      lk(32'h7000_0000, "R9");
      wr(10'h10, 32'h0);
      rd(10'h11, "R9 idx0");

      // R10: out-of-range index and unmapped numbers
      wr(10'h10, 32'h5);
      wr(10'h11, 32'hFFFF_FFFF);
      rd(10'h11, "R10");
      for (int i = 0; i < 4; i++) rd(10'(10'h40 + i), "R10");
      wr(10'h44, 32'hFFFF_FFFF);
      rd(10'h44, "R10");
      rd(10'h3F, "R10");
      for (int i = 0; i < 4; i++) rd(10'(10'h40 + i), "R10");
      @(negedge clk);
      cfg_valid = 1'b0; cfg_num = 10'h40;
      #1;
      check(cfg_rdata === 32'h0, "R10 idle", cfg_rdata, 32'h0);

      // Random mix of writes, reads and lookups near window edges
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 3));
         v = $urandom();
         if ($urandom_range(0, 3) != 0) v[0] = 1'b1;
         case (op)
            0: wr(10'(10'h40 + $urandom_range(0, 3)), v);
            1: begin
               wr(10'h10, 32'($urandom_range(0, 5)));
               wr(10'h11, v);
            end
            2: begin
               logic [9:0] nums [7];
               nums = '{10'h40, 10'h41, 10'h42, 10'h43, 10'h10, 10'h11, 10'h44};
               rd(nums[$urandom_range(0, 6)], "R2/R9/R10 random");
            end
            default: begin
               int b;
               b = int'($urandom_range(0, 3));
               base = {m_bank[b][31:23], 23'b0};
               end64 = {32'b0, base} + (64'(1024 - int'(m_bank[b][15:6])) << 23);
               lk(base, "R5/R7 random base");
               lk(base - 32'd1, "R5 random below");
               lk(end64[31:0] - 32'd1, "R5 random last");
               lk(end64[31:0], "R5 random past");
               lk($urandom(), "R8 random");
            end
         endcase
      end

      finish_run();
   end

endmodule